// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins two 18-bit buses, A and B, with one storage lane per direction. Each lane is steered by its own latch enable and strobe. With the latch enable high the lane follows its source bus. With the enable low it keeps its content, except on a rising strobe, which captures the source bus. A third input per direction decides whether the lane drives the far bus or leaves it released. The A-to-B enable is active high. The B-to-A enable is active low.

The model works at cycle level on a system clock, and every control input is sampled on that clock. Each bus pin is split into an incoming level (`*_in`), a per-bit flag telling whether something outside drives that bit (`*_ext_en`), and the block's own driver (`*_out` plus `*_en`). An outside integration layer joins these into a real tri-state pad. A keeper on each bus supplies the level seen by the lane that reads that bus. When the block's own far-side lane drives the bus, the keeper takes that value. Otherwise it takes the outside driver on every bit that has one. A bit that nobody drives holds its last level.

Data is non-inverting. Both stored words and both drivers show their new values one clock after the edge that caused the change.

Top module: `ubt_bus_xcvr`

## Requirements
- R1: A clock edge with `rst` high clears both stored words and both keepers to zero and turns both drivers off (`a_en`=0, `b_en`=0) from the next cycle.
- R2: A clock edge with a lane's latch enable high loads the current level of that lane's source bus. The new value appears on the lane's output (`b_out` for A-to-B, `a_out` for B-to-A) one cycle later, unchanged and not inverted.
- R3: A clock edge with the latch enable low and no 0-to-1 change of the strobe since the previous edge leaves the stored word unchanged. This holds whether the strobe sits high or low.
- R4: A clock edge with the latch enable low, where the strobe was low at the previous edge and is high now, captures the source bus level into the stored word.
- R5: `b_en` equals the value `oe_ab` had at the previous edge (1 = drive B, 0 = release B). `b_out` keeps showing the stored word in both cases.
- R6: `a_en` equals the inverse of the value `oe_ba_n` had at the previous edge (0 = drive A, 1 = release A).
- R7: When the block does not drive a bus, each bit of that bus whose `*_ext_en` bit is 0 keeps the level it had at the previous edge. Bits whose `*_ext_en` bit is 1 take `*_in`.
- R8: When the block drives a bus (its `*_en` is 1), the level that the opposite lane reads from that bus is the block's own driven word. `*_in` is ignored for all bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Level on bus A driven from outside |
| a_ext_en | input | 18 | Per-bit flag: outside driver active on bus A |
| a_out | output | 18 | Word driven onto bus A (B-to-A stored word) |
| a_en | output | 1 | Driver enable for bus A |
| b_in | input | 18 | Level on bus B driven from outside |
| b_ext_en | input | 18 | Per-bit flag: outside driver active on bus B |
| b_out | output | 18 | Word driven onto bus B (A-to-B stored word) |
| b_en | output | 1 | Driver enable for bus B |
| le_ab | input | 1 | A-to-B latch enable, high = follow |
| cp_ab | input | 1 | A-to-B capture strobe, rising change captures |
| oe_ab | input | 1 | A-to-B output enable, active high |
| le_ba | input | 1 | B-to-A latch enable, high = follow |
| cp_ba | input | 1 | B-to-A capture strobe, rising change captures |
| oe_ba_n | input | 1 | B-to-A output enable, active low |

## Verification
Some rules are checked by assertions on every cycle. These cover the storage action in each lane (follow, hold with the strobe steady high or low, capture on a rising strobe), the enable polarity of each direction, the reset clearing, and the per-bit keeper hold on undriven bits. Other behaviours only show up across the bench's scenarios. One is the block's own driver winning over an outside driver. Another is a bus that is partly driven and partly floating feeding the opposite lane. A third is the way the two lanes interact through a shared bus over long mixed sequences, which the reference model follows cycle by cycle.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_FOLLOW  = 2'd1,
    ACT_CAPTURE = 2'd2
  } act_e;

  // Decide what a storage lane does at this clock edge.
  function automatic act_e pick_act(input logic le, input logic cp, input logic cp_prev);
    if (le)                return ACT_FOLLOW;
    else if (cp && !cp_prev) return ACT_CAPTURE;
    else                   return ACT_HOLD;
  endfunction

endpackage

// File: rtl/ubt_keeper.sv
module ubt_keeper #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         own_en,
  input  logic [W-1:0] own_val,
  input  logic [W-1:0] ext_en,
  input  logic [W-1:0] ext_val,
  output logic [W-1:0] level
);

  logic [W-1:0] held;

  // Own driver first, then outside drivers per bit, then the kept level.
  always_comb begin
    if (own_en) level = own_val;
    else        level = (ext_en & ext_val) | (~ext_en & held);
  end

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else     held <= level;
  end

  AST_KEEP_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (!own_en && !$past(rst)) |-> (((level ^ $past(level)) & ~ext_en) == '0)); // R7

  AST_KEEP_CLEAR: assert property (@(posedge clk)
    ($past(rst) && !own_en && ext_en == '0) |-> (level == '0)); // R1

endmodule

// File: rtl/ubt_lane.sv
module ubt_lane #(
  parameter int W       = 18,
  parameter bit OE_HIGH = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         cp,
  input  logic         oe,
  output logic [W-1:0] q,
  output logic         en
);
  import ubt_pkg::*;

  logic cp_prev;
  act_e act;

  always_comb act = pick_act(le, cp, cp_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= '0;
      cp_prev <= 1'b0;
      en      <= 1'b0;
    end else begin
      cp_prev <= cp;
      en      <= (oe == OE_HIGH);
      if (act != ACT_HOLD) q <= din;
    end
  end

  AST_FOLLOW_LOAD: assert property (@(posedge clk) disable iff (rst)
    le |=> (q == $past(din))); // R2

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!le && (!cp || ($past(cp) && !$past(rst)))) |=> $stable(q)); // R3

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!le && cp && !$past(cp)) |=> (q == $past(din))); // R4

  AST_OE_ON: assert property (@(posedge clk) disable iff (rst)
    (oe == OE_HIGH) |=> en); // R5 R6

  AST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    (oe != OE_HIGH) |=> !en); // R5 R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (q == '0 && !en)); // R1

endmodule

// File: rtl/ubt_bus_xcvr.sv
module ubt_bus_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_ext_en,
  output logic [W-1:0] a_out,
  output logic         a_en,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_ext_en,
  output logic [W-1:0] b_out,
  output logic         b_en,
  input  logic         le_ab,
  input  logic         cp_ab,
  input  logic         oe_ab,
  input  logic         le_ba,
  input  logic         cp_ba,
  input  logic         oe_ba_n
);

  localparam int NDIR = 2;  // index 0: A-to-B lane reads bus A; index 1: B-to-A lane reads bus B

  logic [W-1:0] bus_in  [NDIR];
  logic [W-1:0] bus_ext [NDIR];
  logic [W-1:0] bus_lvl [NDIR];
  logic [W-1:0] lane_q  [NDIR];
  logic         lane_le [NDIR];
  logic         lane_cp [NDIR];
  logic         lane_oe [NDIR];
  logic         lane_en [NDIR];

  assign bus_in[0]  = a_in;
  assign bus_in[1]  = b_in;
  assign bus_ext[0] = a_ext_en;
  assign bus_ext[1] = b_ext_en;
  assign lane_le[0] = le_ab;
  assign lane_le[1] = le_ba;
  assign lane_cp[0] = cp_ab;
  assign lane_cp[1] = cp_ba;
  assign lane_oe[0] = oe_ab;
  assign lane_oe[1] = oe_ba_n;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    // The bus read by lane d is driven by the opposite lane.
    ubt_keeper #(.W(W)) u_keep (
      .clk     (clk),
      .rst     (rst),
      .own_en  (lane_en[NDIR-1-d]),
      .own_val (lane_q[NDIR-1-d]),
      .ext_en  (bus_ext[d]),
      .ext_val (bus_in[d]),
      .level   (bus_lvl[d])
    );

    ubt_lane #(.W(W), .OE_HIGH(d == 0)) u_lane (
      .clk (clk),
      .rst (rst),
      .din (bus_lvl[d]),
      .le  (lane_le[d]),
      .cp  (lane_cp[d]),
      .oe  (lane_oe[d]),
      .q   (lane_q[d]),
      .en  (lane_en[d])
    );
  end

  assign b_out = lane_q[0];
  assign b_en  = lane_en[0];
  assign a_out = lane_q[1];
  assign a_en  = lane_en[1];

endmodule

// File: tb/ubt_bus_xcvr_test.sv
module ubt_bus_xcvr_test;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, a_ext_en = '0, b_in = '0, b_ext_en = '0;
  logic le_ab = 1'b0, cp_ab = 1'b0, oe_ab = 1'b0;
  logic le_ba = 1'b0, cp_ba = 1'b0, oe_ba_n = 1'b1;
  logic [W-1:0] a_out, b_out;
  logic a_en, b_en;

  int vectors = 0;
  int fails   = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  ubt_bus_xcvr #(.W(W)) uut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_ext_en(a_ext_en), .a_out(a_out), .a_en(a_en),
    .b_in(b_in), .b_ext_en(b_ext_en), .b_out(b_out), .b_en(b_en),
    .le_ab(le_ab), .cp_ab(cp_ab), .oe_ab(oe_ab),
    .le_ba(le_ba), .cp_ba(cp_ba), .oe_ba_n(oe_ba_n)
  );

  // Behavioural reference: bus levels, stored words, strobe history, drivers.
  logic [W-1:0] m_ab = '0, m_ba = '0, m_keep_a = '0, m_keep_b = '0;
  logic m_cp_ab = 1'b0, m_cp_ba = 1'b0, m_en_a = 1'b0, m_en_b = 1'b0;

  always @(posedge clk) begin : model
    logic [W-1:0] lvl_a, lvl_b;
    for (int i = 0; i < W; i++) begin
      lvl_a[i] = m_en_a ? m_ba[i] : (a_ext_en[i] ? a_in[i] : m_keep_a[i]);
      lvl_b[i] = m_en_b ? m_ab[i] : (b_ext_en[i] ? b_in[i] : m_keep_b[i]);
    end
    if (rst) begin
      m_ab = '0; m_ba = '0; m_keep_a = '0; m_keep_b = '0;
      m_cp_ab = 1'b0; m_cp_ba = 1'b0; m_en_a = 1'b0; m_en_b = 1'b0;
    end else begin
      if (le_ab || (cp_ab && !m_cp_ab)) m_ab = lvl_a;
      if (le_ba || (cp_ba && !m_cp_ba)) m_ba = lvl_b;
      m_keep_a = lvl_a;
      m_keep_b = lvl_b;
      m_cp_ab  = cp_ab;
      m_cp_ba  = cp_ba;
      m_en_b   = oe_ab;
      m_en_a   = !oe_ba_n;
    end
  end

  task automatic compare();
    vectors++;
    if (b_out !== m_ab || b_en !== m_en_b || a_out !== m_ba || a_en !== m_en_a) begin
      fails++;
      $display("FAIL %s: b_out=%h b_en=%b a_out=%h a_en=%b expected b_out=%h b_en=%b a_out=%h a_en=%b",
               cur_req, b_out, b_en, a_out, a_en, m_ab, m_en_b, m_ba, m_en_a);
    end
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all R1..R8): run did not end, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    // R1 reset state
    cur_req = "R1";
    tick(); tick();
    chk("R1 b_out", b_out, '0);
    chk("R1 enables", {16'd0, a_en, b_en}, '0);
    rst = 1'b0;

    // R2 follow mode A-to-B, R5 driver on
    cur_req = "R2";
    a_ext_en = '1; a_in = 18'h2A5C3; le_ab = 1'b1; oe_ab = 1'b1;
    tick();
    chk("R2 follow", b_out, 18'h2A5C3);
    chk("R5 b_en on", {17'd0, b_en}, 18'd1);
    a_in = 18'h15A3C;
    tick();
    chk("R2 follow again", b_out, 18'h15A3C);

    // R3 hold with strobe low
    cur_req = "R3";
    le_ab = 1'b0; a_in = 18'h3FFFF;
    tick(); tick();
    chk("R3 hold strobe low", b_out, 18'h15A3C);

    // R4 capture on rising strobe, R3 hold with strobe high
    cur_req = "R4";
    cp_ab = 1'b1;
    tick();
    chk("R4 capture", b_out, 18'h3FFFF);
    cur_req = "R3";
    a_in = 18'h00F0F;
    tick();
    chk("R3 hold strobe high", b_out, 18'h3FFFF);
    cp_ab = 1'b0;
    tick();
    chk("R3 hold after fall", b_out, 18'h3FFFF);
    cur_req = "R4";
    cp_ab = 1'b1;
    tick();
    chk("R4 second capture", b_out, 18'h00F0F);
    cp_ab = 1'b0;

    // R5 release B
    cur_req = "R5";
    oe_ab = 1'b0;
    tick();
    chk("R5 b_en off", {17'd0, b_en}, '0);
    chk("R5 word kept", b_out, 18'h00F0F);

    // R6 B-to-A with active-low enable
    cur_req = "R6";
    b_ext_en = '1; b_in = 18'h1C71C; le_ba = 1'b1; oe_ba_n = 1'b1;
    tick();
    chk("R6 a_en off", {17'd0, a_en}, '0);
    chk("R2 B-to-A follow", a_out, 18'h1C71C);
    oe_ba_n = 1'b0;
    tick();
    chk("R6 a_en on", {17'd0, a_en}, 18'd1);

    // R3 and R4 in the B-to-A lane
    cur_req = "R4";
    le_ba = 1'b0; b_in = 18'h2AAAA;
    tick();
    chk("R3 B-to-A hold", a_out, 18'h1C71C);
    cp_ba = 1'b1;
    tick();
    chk("R4 B-to-A capture", a_out, 18'h2AAAA);
    cp_ba = 1'b0;

    // R8 own driver wins over outside driver on bus A
    cur_req = "R8";
    a_ext_en = '1; a_in = 18'h12345; le_ab = 1'b1;
    tick();
    chk("R8 own driver wins", b_out, 18'h2AAAA);

    // R7 bus hold on A after every driver lets go
    cur_req = "R7";
    oe_ba_n = 1'b1;
    tick();
    a_ext_en = '0; a_in = 18'h3C3C3;
    tick();
    chk("R7 full float", b_out, 18'h2AAAA);
    a_ext_en = 18'h001FF;
    tick();
    chk("R7 partial float", b_out, 18'h2ABC3);
    a_ext_en = '0;
    tick();
    chk("R7 float keeps", b_out, 18'h2ABC3);

    // R7 bus hold on B
    b_ext_en = '0; b_in = 18'h05555; le_ba = 1'b1;
    tick();
    chk("R7 B float", a_out, 18'h2AAAA);

    // Mixed random traffic, model compared each cycle
    cur_req = "mixed R2 R3 R4 R5 R6 R7 R8";
    for (int n = 0; n < 600; n++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      a_ext_en = (n % 5 == 0) ? W'($urandom) : ((n % 3 == 0) ? '0 : '1);
      b_ext_en = (n % 7 == 0) ? W'($urandom) : ((n % 4 == 0) ? '0 : '1);
      le_ab = ($urandom % 4) == 0; le_ba = ($urandom % 4) == 0;
      cp_ab = $urandom % 2; cp_ba = $urandom % 2;
      oe_ab = $urandom % 2; oe_ba_n = $urandom % 2;
      tick();
    end

    // R1 reset in mid-run
    cur_req = "R1";
    rst = 1'b1;
    tick();
    chk("R1 mid reset a_out", a_out, '0);
    chk("R1 mid reset b_out", b_out, '0);
    chk("R1 mid reset enables", {16'd0, a_en, b_en}, '0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule